// File: doc/BRIEF.md
# Data Cache Refill Bus Controller

This block connects a processor's data port to a 32-bit single-master memory bus with strobe/acknowledge handshaking. It handles the traffic a small data cache creates. A read of a cacheable word that is not resident becomes a burst of word reads that fills a whole cache line. A read of a non-cacheable word becomes one bus read. Every write is passed through to memory as one bus write. A write that hits a resident line also updates the cached copy. A write that misses allocates nothing. A read that hits is answered from the local arrays with no bus traffic.

The request is taken in the cycle the controller is idle and `cpuReq` is high. In that cycle the address, byte selects, direction, write data and the cacheability verdict are all copied into registers. The bus address and the bus byte-lane selects come only from registers loaded from those copies. The processor side may therefore change its inputs while a transaction is running, and no beat of a refill burst can carry a select value other than all four lanes. A request that would put a bus cycle on the wire with no lanes selected is finished locally.

The tag, valid and data storage are plain register arrays. The line length and the number of lines are parameters.

Top module: `dcr_top`

## Requirements
- R1: A request is cacheable exactly when byte-address bits [31:28] are 4'b0000 or 4'b1111; any other value marks it non-cacheable. The verdict is taken when the request is accepted. A non-cacheable read never fills a line, so repeating it goes to the bus again.
- R2: A cacheable read miss issues LINE_WORDS (default 4) consecutive bus reads. The first is at the line-aligned word address, and the word offset goes up by one after each acknowledged beat. Strobe and cycle stay high until the last acknowledge.
- R3: Every beat of a line refill drives busSel = 4'b1111. This holds whatever the processor drives on its inputs after acceptance, including cpuSel = 4'b0000 at request time.
- R4: A non-cacheable read with a non-zero select issues exactly one bus read. It uses the request's word address and the byte selects captured at acceptance, and returns the bus data to the processor.
- R5: A write with a non-zero select issues exactly one bus cycle with busWe = 1. It carries the captured word address, byte selects and write data.
- R6: A write that hits a resident line updates only the selected byte lanes of the cached word. A write that misses does not allocate a line, so a later read of that line performs a full refill and returns the written bytes.
- R7: A cacheable read hit makes no bus cycle. It asserts cpuAck in the second cycle after acceptance, with the cached word on cpuRdata.
- R8: Each transaction ends with cpuAck high for exactly one cycle. After a refill, cpuRdata holds the requested word of the line and the line's tag and valid bit are set, so the next read of that line hits.
- R9: A write, or a non-cacheable read, whose captured select is 4'b0000 makes no bus cycle. It is acknowledged to the processor with cpuRdata = 0 and leaves memory and cache unchanged.
- R10: busStb is never high with busSel = 4'b0000. busCyc is high whenever busStb is high. While busStb is high and busAck is low, busAdr and busSel hold their values.
- R11: While rst is high, busStb, busCyc, busWe and cpuAck are low from the next clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Request valid; held high until cpuAck |
| cpuAddr | input | ADDR_W-2 | Request word address (byte address bits 31:2) |
| cpuSel | input | 4 | Request byte-lane selects |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWdata | input | 32 | Write data |
| cpuAck | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid while cpuAck is high |
| busAdr | output | ADDR_W-2 | Bus word address |
| busSel | output | 4 | Bus byte-lane selects |
| busWdata | output | 32 | Bus write data |
| busWe | output | 1 | Bus write enable |
| busCyc | output | 1 | Bus cycle in progress |
| busStb | output | 1 | Bus strobe, one beat per acknowledge |
| busAck | input | 1 | Bus beat acknowledge |
| busRdata | input | 32 | Bus read data |

## Verification
The properties assume three things about the inputs. Memory raises busAck only while busStb is high, and completes one beat per acknowledge. The processor holds cpuReq high from acceptance until it sees cpuAck, and drops it in that same cycle. After acceptance the processor may drive anything at all on its other request inputs. The bench's memory model acknowledges only strobed beats, after random waits, and it updates its own contents on acknowledged writes. Between acceptance and cpuAck, the request task replaces address, select, direction and write data with random values on every cycle. This exercises the held decision and the all-lanes select without breaking what the properties take for granted.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

  localparam int DCR_DATA_W   = 32;
  localparam int DCR_SEL_W    = DCR_DATA_W / 8;
  localparam int DCR_WORD_LSB = $clog2(DCR_SEL_W);
  localparam int DCR_REGION_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_REFILL,
    ST_UNC_READ,
    ST_WRITE,
    ST_DONE
  } dcr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadRefill;
    logic loadSingle;
    logic beatAck;
    logic finishRefill;
    logic loadHitData;
    logic loadSingleData;
    logic clearResp;
    logic writeUpdate;
  } dcr_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic isWrite;
    logic inhibit;
    logic hit;
    logic selZero;
    logic lastBeat;
  } dcr_stat_t;

endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuReq,
  input  logic       busAck,
  input  dcr_stat_t  stat,
  output dcr_ctl_t   ctl,
  output dcr_state_e state,
  output logic       busCyc,
  output logic       busStb,
  output logic       busWe,
  output logic       cpuAck
);

  dcr_state_e nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          ctl.capture = 1'b1;
          nextState   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (stat.isWrite) begin
          if (stat.selZero) begin
            ctl.clearResp = 1'b1;
            nextState     = ST_DONE;
          end else begin
            ctl.loadSingle = 1'b1;
            nextState      = ST_WRITE;
          end
        end else if (stat.inhibit) begin
          if (stat.selZero) begin
            ctl.clearResp = 1'b1;
            nextState     = ST_DONE;
          end else begin
            ctl.loadSingle = 1'b1;
            nextState      = ST_UNC_READ;
          end
        end else if (stat.hit) begin
          ctl.loadHitData = 1'b1;
          nextState       = ST_DONE;
        end else begin
          ctl.loadRefill = 1'b1;
          nextState      = ST_REFILL;
        end
      end
      ST_REFILL: begin
        if (busAck) begin
          ctl.beatAck = 1'b1;
          if (stat.lastBeat) begin
            ctl.finishRefill = 1'b1;
            nextState        = ST_DONE;
          end
        end
      end
      ST_UNC_READ: begin
        if (busAck) begin
          ctl.loadSingleData = 1'b1;
          nextState          = ST_DONE;
        end
      end
      ST_WRITE: begin
        if (busAck) begin
          ctl.writeUpdate = 1'b1;
          nextState       = ST_DONE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign busStb = (state == ST_REFILL) || (state == ST_UNC_READ) || (state == ST_WRITE);
  assign busCyc = busStb;
  assign busWe  = (state == ST_WRITE);
  assign cpuAck = (state == ST_DONE);

endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LINES  = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:DCR_WORD_LSB]   cpuAddr,
  input  logic [DCR_SEL_W-1:0]           cpuSel,
  input  logic                           cpuWe,
  input  logic [DCR_DATA_W-1:0]          cpuWdata,
  input  logic [DCR_DATA_W-1:0]          busRdata,
  input  dcr_ctl_t                       ctl,
  output dcr_stat_t                      stat,
  output logic [DCR_DATA_W-1:0]          cpuRdata,
  output logic [ADDR_W-1:DCR_WORD_LSB]   busAdr,
  output logic [DCR_SEL_W-1:0]           busSel,
  output logic [DCR_DATA_W-1:0]          busWdata
);

  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int IDX_W    = $clog2(NUM_LINES);
  localparam int LINE_LSB = DCR_WORD_LSB + OFF_W;
  localparam int TAG_LSB  = LINE_LSB + IDX_W;
  localparam int TAG_W    = ADDR_W - TAG_LSB;
  localparam int ENTRIES  = NUM_LINES * LINE_WORDS;

  // request copies taken at acceptance
  logic [ADDR_W-1:DCR_WORD_LSB] reqWord;
  logic [DCR_SEL_W-1:0]         reqSel;
  logic                         reqWe;
  logic [DCR_DATA_W-1:0]        reqData;
  logic                         reqInhibit;

  // bus-facing registers
  logic [ADDR_W-1:DCR_WORD_LSB] busWord;
  logic [DCR_SEL_W-1:0]         busSelReg;
  logic [DCR_DATA_W-1:0]        rspData;

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [OFF_W-1:0] busOff;
  logic             regionOk;
  logic             hitNow;

  logic [TAG_W-1:0]      tagArr   [NUM_LINES];
  logic [NUM_LINES-1:0]  validArr;
  logic [NUM_LINES-1:0]  lineHit;
  logic [DCR_DATA_W-1:0] dataArr  [ENTRIES];

  assign reqOff = reqWord[LINE_LSB-1:DCR_WORD_LSB];
  assign reqIdx = reqWord[TAG_LSB-1:LINE_LSB];
  assign reqTag = reqWord[ADDR_W-1:TAG_LSB];
  assign busOff = busWord[LINE_LSB-1:DCR_WORD_LSB];

  assign regionOk = (cpuAddr[ADDR_W-1 -: DCR_REGION_W] == '0) ||
                    (cpuAddr[ADDR_W-1 -: DCR_REGION_W] == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      reqWord    <= '0;
      reqSel     <= '0;
      reqWe      <= 1'b0;
      reqData    <= '0;
      reqInhibit <= 1'b0;
      busWord    <= '0;
      busSelReg  <= '0;
      rspData    <= '0;
    end else begin
      if (ctl.capture) begin
        reqWord    <= cpuAddr;
        reqSel     <= cpuSel;
        reqWe      <= cpuWe;
        reqData    <= cpuWdata;
        reqInhibit <= !regionOk;
      end
      if (ctl.loadRefill) begin
        busWord   <= {reqWord[ADDR_W-1:LINE_LSB], {OFF_W{1'b0}}};
        busSelReg <= '1;
      end
      if (ctl.loadSingle) begin
        busWord   <= reqWord;
        busSelReg <= reqSel;
      end
      if (ctl.beatAck) begin
        busWord[LINE_LSB-1:DCR_WORD_LSB] <= busOff + OFF_W'(1);
        if (busOff == reqOff) rspData <= busRdata;
      end
      if (ctl.loadHitData)    rspData <= dataArr[{reqIdx, reqOff}];
      if (ctl.loadSingleData) rspData <= busRdata;
      if (ctl.clearResp)      rspData <= '0;
    end
  end

  // per-line tag and valid storage
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (rst) begin
        validArr[g] <= 1'b0;
        tagArr[g]   <= '0;
      end else if (ctl.finishRefill && (reqIdx == IDX_W'(g))) begin
        validArr[g] <= 1'b1;
        tagArr[g]   <= reqTag;
      end
    end
    assign lineHit[g] = validArr[g] && (tagArr[g] == reqTag);
  end

  assign hitNow = lineHit[reqIdx] && !reqInhibit;

  // line data storage
  always_ff @(posedge clk) begin
    if (ctl.beatAck) dataArr[{reqIdx, busOff}] <= busRdata;
    if (ctl.writeUpdate && hitNow) begin
      for (int b = 0; b < DCR_SEL_W; b++) begin
        if (reqSel[b]) dataArr[{reqIdx, reqOff}][8*b +: 8] <= reqData[8*b +: 8];
      end
    end
  end

  assign stat.isWrite  = reqWe;
  assign stat.inhibit  = reqInhibit;
  assign stat.hit      = hitNow;
  assign stat.selZero  = (reqSel == '0);
  assign stat.lastBeat = (busOff == '1);

  assign cpuRdata = rspData;
  assign busAdr   = busWord;
  assign busSel   = busSelReg;
  assign busWdata = reqData;

endmodule

// File: rtl/dcr_top.sv
module dcr_top
  import dcr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LINES  = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpuReq,
  input  logic [ADDR_W-1:DCR_WORD_LSB] cpuAddr,
  input  logic [DCR_SEL_W-1:0]         cpuSel,
  input  logic                         cpuWe,
  input  logic [DCR_DATA_W-1:0]        cpuWdata,
  output logic                         cpuAck,
  output logic [DCR_DATA_W-1:0]        cpuRdata,
  output logic [ADDR_W-1:DCR_WORD_LSB] busAdr,
  output logic [DCR_SEL_W-1:0]         busSel,
  output logic [DCR_DATA_W-1:0]        busWdata,
  output logic                         busWe,
  output logic                         busCyc,
  output logic                         busStb,
  input  logic                         busAck,
  input  logic [DCR_DATA_W-1:0]        busRdata
);

  dcr_ctl_t   ctl;
  dcr_stat_t  stat;
  dcr_state_e curState;

  dcr_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .cpuReq (cpuReq),
    .busAck (busAck),
    .stat   (stat),
    .ctl    (ctl),
    .state  (curState),
    .busCyc (busCyc),
    .busStb (busStb),
    .busWe  (busWe),
    .cpuAck (cpuAck)
  );

  dcr_datapath #(
    .ADDR_W     (ADDR_W),
    .NUM_LINES  (NUM_LINES),
    .LINE_WORDS (LINE_WORDS)
  ) uData (
    .clk      (clk),
    .rst      (rst),
    .cpuAddr  (cpuAddr),
    .cpuSel   (cpuSel),
    .cpuWe    (cpuWe),
    .cpuWdata (cpuWdata),
    .busRdata (busRdata),
    .ctl      (ctl),
    .stat     (stat),
    .cpuRdata (cpuRdata),
    .busAdr   (busAdr),
    .busSel   (busSel),
    .busWdata (busWdata)
  );

endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
  import dcr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         busStb,
  input logic                         busCyc,
  input logic                         busWe,
  input logic                         busAck,
  input logic                         cpuAck,
  input logic [ADDR_W-1:DCR_WORD_LSB] busAdr,
  input logic [DCR_SEL_W-1:0]         busSel,
  input dcr_state_e                   curState
);

  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int LINE_LSB = DCR_WORD_LSB + OFF_W;
  localparam int WADDR_W  = ADDR_W - DCR_WORD_LSB;

  assert_sel_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    busStb |-> (busSel != '0));

  assert_cyc_with_stb_R10: assert property (@(posedge clk) disable iff (rst)
    busStb |-> busCyc);

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (rst)
    (busStb && !busAck) |=> (busStb && $stable(busAdr) && $stable(busSel)));

  assert_refill_sel_R3: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_REFILL && busStb) |-> (busSel == '1 && !busWe));

  assert_refill_step_R2: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_REFILL && busAck && busAdr[LINE_LSB-1:DCR_WORD_LSB] != '1)
      |=> (busStb && busAdr == $past(busAdr) + WADDR_W'(1)));

  assert_write_we_R5: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_WRITE) |-> (busStb && busWe));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    cpuAck |=> !cpuAck);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!busStb && !busCyc && !busWe && !cpuAck));

endmodule

bind dcr_top dcr_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_WORDS (LINE_WORDS)
) uChecker (
  .clk      (clk),
  .rst      (rst),
  .busStb   (busStb),
  .busCyc   (busCyc),
  .busWe    (busWe),
  .busAck   (busAck),
  .cpuAck   (cpuAck),
  .busAdr   (busAdr),
  .busSel   (busSel),
  .curState (curState)
);

// File: tb/dcr_top_test.sv
module dcr_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpuReq = 1'b0;
  logic [31:2] cpuAddr = '0;
  logic [3:0]  cpuSel = '0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic        cpuAck;
  logic [31:0] cpuRdata;
  logic [31:2] busAdr;
  logic [3:0]  busSel;
  logic [31:0] busWdata;
  logic        busWe, busCyc, busStb;
  logic        busAck = 1'b0;
  logic [31:0] busRdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcr_top uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuAddr(cpuAddr), .cpuSel(cpuSel),
    .cpuWe(cpuWe), .cpuWdata(cpuWdata), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .busAdr(busAdr), .busSel(busSel), .busWdata(busWdata), .busWe(busWe),
    .busCyc(busCyc), .busStb(busStb), .busAck(busAck), .busRdata(busRdata)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [31:0] memW [logic [31:0]];

  function automatic logic [31:0] hashWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ {a[15:0], a[31:16]};
  endfunction

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (memW.exists(a)) return memW[a];
    return hashWord(a);
  endfunction

  function automatic logic [31:0] mergeBytes(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // bus beat log
  int          nBeats = 0;
  int          zeroSelStb = 0;
  logic [31:0] bAdr [8];
  logic [3:0]  bSel [8];
  logic        bWe  [8];
  logic [31:0] bDat [8];

  always @(negedge clk) begin
    logic [31:0] a;
    busAck = 1'b0;
    if (!rst && busStb) begin
      if (busSel == 4'b0000) zeroSelStb++;
      if ($urandom_range(0, 2) != 0) begin
        a = {busAdr, 2'b00};
        busAck = 1'b1;
        busRdata = memRead(a);
        if (busWe) memW[a] = mergeBytes(memRead(a), busWdata, busSel);
        if (nBeats < 8) begin
          bAdr[nBeats] = a;
          bSel[nBeats] = busSel;
          bWe[nBeats]  = busWe;
          bDat[nBeats] = busWdata;
        end
        nBeats++;
      end
    end
  end

  // shadow tags
  logic        shValid [4];
  logic [25:0] shTag   [4];

  function automatic logic [31:0] mkAddr(input logic [3:0] top, input int t, input int idx, input int off);
    return {top, 22'(t), 2'(idx), 2'(off), 2'b00};
  endfunction

  task automatic txn(input logic [31:0] a, input logic [3:0] s, input logic w,
                     input logic [31:0] d, input string rdTag);
    bit          cach, hit;
    int          idx, cyc;
    logic [31:0] expRd, rd;
    cach  = (a[31:28] == 4'h0) || (a[31:28] == 4'hF);
    idx   = int'(a[5:4]);
    hit   = cach && shValid[idx] && (shTag[idx] == a[31:6]);
    expRd = memRead(a);
    @(negedge clk);
    nBeats = 0;
    zeroSelStb = 0;
    cpuReq = 1'b1; cpuAddr = a[31:2]; cpuSel = s; cpuWe = w; cpuWdata = d;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpuAck) break;
      if (cyc > 200) break;
      cpuAddr  = 30'($urandom);
      cpuSel   = 4'($urandom);
      cpuWe    = 1'($urandom);
      cpuWdata = $urandom;
    end
    chk(cpuAck == 1'b1, "R8 ack arrives", 32'(cpuAck), 32'd1);
    rd = cpuRdata;
    cpuReq = 1'b0;
    @(negedge clk);
    chk(cpuAck == 1'b0, "R8 ack one cycle", 32'(cpuAck), 32'd0);
    chk(zeroSelStb == 0, "R10 no zero-select strobe", 32'(zeroSelStb), 32'd0);
    if (!w && cach) begin
      if (hit) begin
        chk(nBeats == 0, "R7 hit no bus", 32'(nBeats), 32'd0);
        chk(cyc == 2, "R7 hit latency", 32'(cyc), 32'd2);
        chk(rd == expRd, rdTag, rd, expRd);
      end else begin
        chk(nBeats == 4, "R2 refill beat count", 32'(nBeats), 32'd4);
        for (int i = 0; i < 4 && i < nBeats; i++) begin
          chk(bAdr[i] == {a[31:4], 2'(i), 2'b00}, "R2 refill beat address", bAdr[i], {a[31:4], 2'(i), 2'b00});
          chk(bSel[i] == 4'hF, "R3 refill select", 32'(bSel[i]), 32'hF);
          chk(bWe[i] == 1'b0, "R2 refill is read", 32'(bWe[i]), 32'd0);
        end
        chk(rd == expRd, rdTag, rd, expRd);
        shValid[idx] = 1'b1;
        shTag[idx]   = a[31:6];
      end
    end else if (!w) begin
      if (s == 4'b0000) begin
        chk(nBeats == 0, "R9 zero-select read no bus", 32'(nBeats), 32'd0);
        chk(rd == 32'd0, "R9 zero-select read data", rd, 32'd0);
      end else begin
        chk(nBeats == 1, "R1 uncached single beat", 32'(nBeats), 32'd1);
        chk(bAdr[0] == {a[31:2], 2'b00}, "R4 uncached address", bAdr[0], {a[31:2], 2'b00});
        chk(bSel[0] == s, "R4 uncached select", 32'(bSel[0]), 32'(s));
        chk(rd == expRd, rdTag, rd, expRd);
      end
    end else begin
      if (s == 4'b0000) begin
        chk(nBeats == 0, "R9 zero-select write no bus", 32'(nBeats), 32'd0);
        chk(rd == 32'd0, "R9 zero-select write data", rd, 32'd0);
      end else begin
        chk(nBeats == 1, "R5 write single beat", 32'(nBeats), 32'd1);
        chk(bWe[0] == 1'b1, "R5 write enable", 32'(bWe[0]), 32'd1);
        chk(bAdr[0] == {a[31:2], 2'b00}, "R5 write address", bAdr[0], {a[31:2], 2'b00});
        chk(bSel[0] == s, "R5 write select", 32'(bSel[0]), 32'(s));
        chk(bDat[0] == d, "R5 write data", bDat[0], d);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] tops [2];
    logic [3:0] uncTops [4];
    logic [3:0] sels [8];
    logic [31:0] a;
    tops = '{4'h0, 4'hF};
    uncTops = '{4'h1, 4'h7, 4'h8, 4'hE};
    sels = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF, 4'h5};
    for (int i = 0; i < 4; i++) begin shValid[i] = 1'b0; shTag[i] = '0; end

    // R11: reset
    repeat (3) @(negedge clk);
    chk(busStb == 1'b0, "R11 reset strobe", 32'(busStb), 32'd0);
    chk(busCyc == 1'b0, "R11 reset cycle", 32'(busCyc), 32'd0);
    chk(busWe == 1'b0, "R11 reset write enable", 32'(busWe), 32'd0);
    chk(cpuAck == 1'b0, "R11 reset ack", 32'(cpuAck), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R8: cold refills with evictions
    for (int ti = 0; ti < 2; ti++)
      for (int t = 0; t < 2; t++)
        for (int idx = 0; idx < 4; idx++)
          txn(mkAddr(tops[ti], t, idx, (idx + t) % 4), 4'($urandom), 1'b0, 32'd0, "R8 refill word");

    // R7: hits on every word of resident lines
    for (int idx = 0; idx < 4; idx++)
      for (int off = 0; off < 4; off++)
        txn(mkAddr(4'hF, 1, idx, off), 4'($urandom_range(1, 15)), 1'b0, 32'd0, "R7 hit data");

    // R1 R4: non-cacheable reads, repeated to show no allocation
    for (int u = 0; u < 4; u++)
      for (int si = 0; si < 8; si++) begin
        a = mkAddr(uncTops[u], si % 2, si % 4, u);
        txn(a, sels[si], 1'b0, 32'd0, "R4 uncached data");
        txn(a, sels[si], 1'b0, 32'd0, "R1 uncached repeat");
      end

    // R5 R6: write hits under every non-zero select, read back
    for (int idx = 0; idx < 4; idx++)
      for (int s = 1; s < 16; s++) begin
        a = mkAddr(4'hF, 1, idx, s % 4);
        txn(a, 4'(s), 1'b1, $urandom, "R5 write");
        txn(a, 4'($urandom), 1'b0, 32'd0, "R6 write hit merged");
      end

    // R6: write miss, no allocation, then refill sees written bytes
    for (int idx = 0; idx < 4; idx++) begin
      a = mkAddr(4'h0, 0, idx, 1);
      txn(a, 4'h6, 1'b1, $urandom, "R5 write");
      txn(a, 4'hF, 1'b0, 32'd0, "R6 write miss refill data");
    end

    // R5: non-cacheable write then read
    a = mkAddr(4'h7, 3, 2, 3);
    txn(a, 4'h9, 1'b1, 32'hCAFE_1234, "R5 write");
    txn(a, 4'hF, 1'b0, 32'd0, "R5 uncached write visible");

    // R9: zero-select requests
    txn(mkAddr(4'h8, 1, 1, 1), 4'h0, 1'b0, 32'd0, "R9 read");
    txn(mkAddr(4'h8, 1, 1, 1), 4'h0, 1'b1, 32'hFFFF_FFFF, "R9 write");
    a = mkAddr(4'h0, 0, 2, 1);
    txn(a, 4'h0, 1'b1, 32'h0BAD_0BAD, "R9 write");
    txn(a, 4'hF, 1'b0, 32'd0, "R9 cached word unchanged");
    txn(mkAddr(4'h8, 1, 1, 1), 4'hF, 1'b0, 32'd0, "R9 memory unchanged");

    // R3: cacheable read with zero select still refills with all lanes
    txn(mkAddr(4'hF, 2, 3, 2), 4'h0, 1'b0, 32'd0, "R3 zero-select refill data");
    txn(mkAddr(4'hF, 2, 3, 0), 4'h0, 1'b0, 32'd0, "R7 hit after refill");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule